// File: doc/BRIEF.md
# Password-Locked Configuration Register File

This block is a small bank of byte-wide configuration registers. It sits behind a simple single-cycle address/data/write-strobe bus, such as the register side of a serial slave. Most registers take a write directly. Registers in the protected window take a write only after a key has been written to a dedicated key register. The key is tied to the register being targeted. A few registers need the whole key-plus-data exchange done twice, with the same data both times, before the new value takes effect.

Software unlocks a register by writing `target XOR 0x7D` to the key register at 0x0B. The next bus access must be the data write to that target. Any other access in between cancels the unlock: a read, a write elsewhere, or a bad key. Protected writes that arrive without a valid unlock are dropped and raise a sticky error bit. Reads always return the committed contents, combinationally from the presented address.

Top module: `cfg_lock_regfile`

## Requirements
- R1: After reset, address 0x13 reads 0x38, 0x15 reads 0x3F, 0x18 reads 0x03, every other address reads 0x00, and `err_flag` is 0.
- R2: Addresses 0x00–0x0A and 0x0C–0x0F are unprotected and store a write directly, readable on the next cycle.
- R3: A write to the key register 0x0B is never stored as data; reading 0x0B always returns 0x00.
- R4: Addresses 0x10–0x1F are protected. A level-1 protected register (all of them except 0x13 and 0x15) is updated only by a write that immediately follows a key write whose value XOR 0x7D equals that address (for example key 0x65 then a write to 0x18).
- R5: A protected write without a valid immediately preceding unlock is dropped, and it sets `err_flag`, which stays 1 until reset.
- R6: Any bus access other than the expected next step returns the sequence to idle. This includes a read, a write to an unprotected or out-of-range address, and a key write whose value does not map to a protected address.
- R7: Level-2 registers 0x13 and 0x15 are updated only after key, write, key, write on consecutive accesses with the same target. After the first pair alone, the register keeps its old value.
- R8: If the second data write of a level-2 sequence carries data different from the first, the sequence aborts, the register keeps its value, and `err_flag` is not set.
- R9: A valid key for one protected address does not unlock another; a protected write to a different address is dropped and sets `err_flag`.
- R10: Addresses at or above 32 ignore writes and read 0x00.
- R11: `rd_data` reflects the committed value at `bus_addr` combinationally, whether or not `bus_valid` is high. Only accesses with `bus_valid` high affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data or key value |
| rd_data | output | 8 | Committed value at `bus_addr` |
| err_flag | output | 1 | Sticky flag for dropped protected writes |

## Verification
The same protected write can both cancel the unlock and set the error bit. This happens when a second pair of a level-2 sequence is broken by a stray protected write to another address. The bench provokes it by writing a key and then writing to a different protected address. It then judges both effects at the ports: the target keeps its value, and the error bit is high on the next cycle. A read access can also land between a level-2 pair. The bench places such a read there and confirms that the following pair commits nothing and only begins a new sequence.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t KEY_ADDR = 8'h0B;
  localparam data_t KEY_MASK = 8'h7D;
  localparam addr_t PROT_LO  = 8'h10;
  localparam addr_t PROT_HI  = 8'h1F;
  localparam addr_t L2_RAIL_A = 8'h13;
  localparam addr_t L2_RAIL_B = 8'h15;
  localparam addr_t UV_ADDR   = 8'h18;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_UNL1 = 2'd1,
    SQ_HALF = 2'd2,
    SQ_UNL2 = 2'd3
  } seq_state_t;

  // Address unlocked by a key value.
  function automatic addr_t key_target(data_t key);
    return addr_t'(key ^ KEY_MASK);
  endfunction

  function automatic logic is_protected(addr_t a);
    return (a >= PROT_LO) && (a <= PROT_HI);
  endfunction

  function automatic logic is_level2(addr_t a);
    return (a == L2_RAIL_A) || (a == L2_RAIL_B);
  endfunction

  function automatic data_t reset_value(addr_t a);
    case (a)
      L2_RAIL_A: return 8'h38;
      L2_RAIL_B: return 8'h3F;
      UV_ADDR:   return 8'h03;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  addr_t bus_addr,
  input  data_t bus_wdata,
  output logic  in_range,
  output logic  hit_key,
  output logic  hit_prot,
  output logic  hit_l2,
  output logic  key_ok,
  output addr_t key_tgt
);
  localparam addr_t LIMIT = addr_t'(NUM_REGS);

  always_comb begin
    in_range = bus_addr < LIMIT;
    hit_key  = bus_addr == KEY_ADDR;
    hit_prot = in_range && is_protected(bus_addr);
    hit_l2   = hit_prot && is_level2(bus_addr);
    key_tgt  = key_target(bus_wdata);
    key_ok   = (key_tgt < LIMIT) && is_protected(key_tgt);
  end
endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_we,
  input  addr_t      bus_addr,
  input  data_t      bus_wdata,
  input  logic       hit_key,
  input  logic       hit_prot,
  input  logic       hit_l2,
  input  logic       key_ok,
  input  addr_t      key_tgt,
  output logic       commit_en,
  output addr_t      commit_addr,
  output data_t      commit_data,
  output logic       err_set,
  output seq_state_t state_o
);
  seq_state_t state, state_nx;
  addr_t      tgt, tgt_nx;
  data_t      held, held_nx;

  always_comb begin
    state_nx    = state;
    tgt_nx      = tgt;
    held_nx     = held;
    commit_en   = 1'b0;
    commit_addr = bus_addr;
    commit_data = bus_wdata;
    err_set     = 1'b0;
    if (bus_valid) begin
      state_nx = SQ_IDLE;
      if (bus_we && hit_key) begin
        if (key_ok) begin
          tgt_nx   = key_tgt;
          state_nx = (state == SQ_HALF && key_tgt == tgt) ? SQ_UNL2 : SQ_UNL1;
        end
      end else if (bus_we && hit_prot) begin
        unique case (state)
          SQ_UNL1: begin
            if (bus_addr != tgt) err_set = 1'b1;
            else if (hit_l2) begin
              held_nx  = bus_wdata;
              state_nx = SQ_HALF;
            end else commit_en = 1'b1;
          end
          SQ_UNL2: begin
            if (bus_addr != tgt) err_set = 1'b1;
            else if (bus_wdata == held) commit_en = 1'b1;
          end
          default: err_set = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      tgt   <= '0;
      held  <= '0;
    end else begin
      state <= state_nx;
      tgt   <= tgt_nx;
      held  <= held_nx;
    end
  end

  assign state_o = state;
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
  import cfg_lock_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  addr_t rd_addr,
  output data_t rd_data
);
  localparam int    IDX_W = $clog2(NUM_REGS);
  localparam addr_t LIMIT = addr_t'(NUM_REGS);

  data_t mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam addr_t A = addr_t'(i);
    data_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reset_value(A);
      else if (wr_en && wr_addr == A) q <= wr_data;
    end
    assign mem[i] = q;
  end

  always_comb begin
    if (rd_addr < LIMIT && rd_addr != KEY_ADDR) rd_data = mem[rd_addr[IDX_W-1:0]];
    else rd_data = '0;
  end
endmodule

// File: rtl/cfg_lock_regfile.sv
module cfg_lock_regfile
  import cfg_lock_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] rd_data,
  output logic       err_flag
);
  logic       in_range, hit_key, hit_prot, hit_l2, key_ok;
  addr_t      key_tgt;
  logic       commit_en, err_set, direct_we, wr_en;
  addr_t      commit_addr, wr_addr;
  data_t      commit_data, wr_data;
  seq_state_t seq_state;

  cfg_lock_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .in_range (in_range),
    .hit_key  (hit_key),
    .hit_prot (hit_prot),
    .hit_l2   (hit_l2),
    .key_ok   (key_ok),
    .key_tgt  (key_tgt)
  );

  cfg_lock_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .hit_key    (hit_key),
    .hit_prot   (hit_prot),
    .hit_l2     (hit_l2),
    .key_ok     (key_ok),
    .key_tgt    (key_tgt),
    .commit_en  (commit_en),
    .commit_addr(commit_addr),
    .commit_data(commit_data),
    .err_set    (err_set),
    .state_o    (seq_state)
  );

  assign direct_we = bus_valid && bus_we && in_range && !hit_key && !hit_prot;
  assign wr_en     = direct_we || commit_en;
  assign wr_addr   = commit_en ? commit_addr : bus_addr;
  assign wr_data   = commit_en ? commit_data : bus_wdata;

  cfg_lock_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(bus_addr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
  end
endmodule

// File: rtl/cfg_lock_regfile_chk.sv
module cfg_lock_regfile_chk
  import cfg_lock_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] rd_data,
  input logic       err_flag,
  input logic       commit_en,
  input addr_t      commit_addr,
  input seq_state_t seq_state
);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R5
  bare_prot_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && seq_state == SQ_IDLE && is_protected(bus_addr)
     && bus_addr < addr_t'(NUM_REGS)) |=> err_flag);

  // R3
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == KEY_ADDR) |-> (rd_data == '0));

  // R10
  out_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= addr_t'(NUM_REGS)) |-> (rd_data == '0));

  // R4
  commit_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (seq_state == SQ_UNL1 || seq_state == SQ_UNL2));

  // R7
  l2_commit_second_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && is_level2(commit_addr)) |-> (seq_state == SQ_UNL2));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |=> (seq_state == SQ_IDLE));
endmodule

bind cfg_lock_regfile cfg_lock_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .rd_data    (rd_data),
  .err_flag   (err_flag),
  .commit_en  (commit_en),
  .commit_addr(commit_addr),
  .seq_state  (seq_state)
);

// File: tb/cfg_lock_regfile_tb.sv
module cfg_lock_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  cfg_lock_regfile u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_data  (rd_data),
    .err_flag (err_flag)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] key_for(logic [7:0] a);
    return a ^ 8'h7D;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_access(logic [7:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] v);
    bus_valid = 1'b0; bus_addr = a;
    #1 v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 32; a++) begin
      logic [7:0] e;
      e = (a == 8'h13) ? 8'h38 : (a == 8'h15) ? 8'h3F : (a == 8'h18) ? 8'h03 : 8'h00;
      peek(8'(a), v); chk("R1 reset value", v, e);
    end
    chk("R1 err clear", {7'd0, err_flag}, 8'h00);
  endtask

  task automatic t_unprot();
    logic [7:0] v;
    wr(8'h02, 8'h5A); peek(8'h02, v); chk("R2 direct write", v, 8'h5A);
    wr(8'h0F, 8'hC3); peek(8'h0F, v); chk("R2 direct write top", v, 8'hC3);
    peek(8'h02, v); chk("R11 comb read", v, 8'h5A);
  endtask

  task automatic t_key_reg();
    logic [7:0] v;
    wr(8'h0B, 8'h12); peek(8'h0B, v); chk("R3 key not stored", v, 8'h00);
  endtask

  task automatic t_level1();
    logic [7:0] v;
    wr(8'h0B, key_for(8'h18)); wr(8'h18, 8'h00);
    peek(8'h18, v); chk("R4 uv unlock", v, 8'h00);
    wr(8'h0B, key_for(8'h11)); wr(8'h11, 8'hA5);
    peek(8'h11, v); chk("R4 level1 0x11", v, 8'hA5);
  endtask

  task automatic t_level2();
    logic [7:0] v;
    wr(8'h0B, 8'h6E); wr(8'h13, 8'h32);
    peek(8'h13, v); chk("R7 first pair no effect", v, 8'h38);
    wr(8'h0B, 8'h6E); wr(8'h13, 8'h32);
    peek(8'h13, v); chk("R7 0x13 commit", v, 8'h32);
    wr(8'h0B, 8'h68); wr(8'h15, 8'h35); wr(8'h0B, 8'h68); wr(8'h15, 8'h35);
    peek(8'h15, v); chk("R7 0x15 commit", v, 8'h35);
    wr(8'h0B, 8'h68); wr(8'h15, 8'h20); rd_access(8'h00);
    wr(8'h0B, 8'h68); wr(8'h15, 8'h20);
    peek(8'h15, v); chk("R7 read between pairs", v, 8'h35);
  endtask

  task automatic t_mismatch();
    logic [7:0] v;
    wr(8'h0B, 8'h6E); wr(8'h13, 8'h20); wr(8'h0B, 8'h6E); wr(8'h13, 8'h21);
    peek(8'h13, v); chk("R8 mismatch keeps", v, 8'h32);
    chk("R8 no error", {7'd0, err_flag}, 8'h00);
  endtask

  task automatic t_range();
    logic [7:0] v;
    wr(8'h40, 8'h77); peek(8'h40, v); chk("R10 out of range", v, 8'h00);
    peek(8'h20, v); chk("R10 first past end", v, 8'h00);
  endtask

  task automatic t_interrupt();
    logic [7:0] v;
    wr(8'h0B, key_for(8'h18)); rd_access(8'h00); wr(8'h18, 8'h02);
    peek(8'h18, v); chk("R6 read cancels", v, 8'h00);
    chk("R5 err set", {7'd0, err_flag}, 8'h01);
    wr(8'h0B, key_for(8'h18)); wr(8'h03, 8'h11); wr(8'h18, 8'h02);
    peek(8'h18, v); chk("R6 unprot write cancels", v, 8'h00);
    wr(8'h0B, 8'h00); wr(8'h18, 8'h02);
    peek(8'h18, v); chk("R6 bad key", v, 8'h00);
  endtask

  task automatic t_wrong_target();
    logic [7:0] v;
    wr(8'h0B, key_for(8'h18)); wr(8'h11, 8'h3C);
    peek(8'h11, v); chk("R9 wrong target dropped", v, 8'hA5);
    chk("R9 err", {7'd0, err_flag}, 8'h01);
    wr(8'h1E, 8'h44); peek(8'h1E, v); chk("R5 bare write dropped", v, 8'h00);
    chk("R5 err sticky", {7'd0, err_flag}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unprot();
    t_key_reg();
    t_level1();
    t_level2();
    t_mismatch();
    t_range();
    t_interrupt();
    t_wrong_target();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule